// File: doc/BRIEF.md
# Bus Access Breakpoint Comparator

This block watches a processor or DMA bus one access at a time and raises a break pulse when an access hits a programmed location. A hit needs three things: the access address must fall on the programmed location, the access direction (read or write) must be one that the direction selector allows, and, unless size is ignored, the bytes the access touches must share at least one byte with the programmed bytes. Size is compared by byte-lane overlap, not by equality. A word programmed at offset 2 is therefore hit by a word access at offset 2 and also by a long-word access at offset 0.

Only the opening beat of a burst is compared. Beats flagged as burst continuations never break. An access flagged as coming from the external bus is always compared with size ignored, whatever the size-mask field holds. Software programs the block through a two-register write port: one register holds the compare address and the other holds the control fields. Every field resets to zero, and that includes the global enable. The block therefore stays silent until software sets the enable.

A two-state machine drives the output. In ARMED the break is low. ARMED goes to FIRE when the current access hits (transition HIT). FIRE stays in FIRE on another hit (transition REHIT) and falls back to ARMED otherwise (transition MISS). The break output is high exactly while the machine is in FIRE.

Top module: `bkpt_cmp`

## Requirements
- R1: After reset the compare address and all control fields are zero, the machine is in ARMED and `brk` is low.
- R2: While the enable field (control bit 0) is 0, `brk` never rises, whatever the access.
- R3: Direction field, control bits [2:1]: 00 hits reads only (`acc_rd`=1), 01 hits writes only (`acc_rd`=0), 10 hits both.
- R4: Direction code 11 is reserved and never produces a hit.
- R5: Address bits above bit 1 must equal the programmed address exactly, whatever the mode.
- R6: Size codes on `acc_size` and control bits [5:4] are 00 = 4 bytes, 01 = 1 byte, 10 = 2 bytes, 11 = 3 bytes. The bytes covered run upward from address offset `addr[1:0]` and are clipped at the end of the aligned long word. With size-mask (control bit 3) at 0, a hit needs these byte sets of the access and of the programmed value to overlap.
- R7: With a 2-byte value programmed at offset 2, a 2-byte access at offset 2 and a 4-byte access at offset 0 both hit, and a 2-byte access at offset 0 does not.
- R8: With size-mask at 1, size is ignored and a hit needs the full access address to equal the programmed address.
- R9: An access with `acc_ext`=1 is compared as if size-mask were 1.
- R10: An access with `acc_cont`=1 (a later burst beat) never produces a hit.
- R11: `brk` is high in the cycle after each valid hitting access and for that one cycle only. Back-to-back hits keep it high on consecutive cycles. It stays low after any cycle in which `acc_valid` is low.
- R12: On a clock edge with `cfg_wr`=1, `cfg_sel`=0 loads `cfg_wdata` into the compare address and `cfg_sel`=1 loads the control bits [5:0]. The new value governs accesses from the next cycle on. An access in the same cycle as the write is compared against the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 = compare address, 1 = control |
| cfg_wdata | input | ADDR_W | Register write data |
| acc_valid | input | 1 | An access is on the bus this cycle |
| acc_addr | input | ADDR_W | Access byte address |
| acc_rd | input | 1 | 1 = read, 0 = write |
| acc_size | input | 2 | Access size code |
| acc_cont | input | 1 | Access is a later beat of a burst |
| acc_ext | input | 1 | Access is on the external bus |
| brk | output | 1 | Break pulse, registered |

## Verification
A break is due exactly one clock edge after the access that causes it, because it passes through the state register and nothing else. A register write takes effect for an access presented one edge after the write. The bench drives inputs on the falling edge and updates its behavioural model at the rising edge that follows. It compares `brk` with the model's registered expectation at the next falling edge, on every cycle, so any off-by-one in either latency shows up as a mismatch.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    typedef enum logic [1:0] {
        DIR_RD   = 2'b00,
        DIR_WR   = 2'b01,
        DIR_ANY  = 2'b10,
        DIR_RSVD = 2'b11
    } bk_dir_e;

    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_WORD = 2'b10,
        SZ_TRI  = 2'b11
    } bk_size_e;

    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_FIRE  = 1'b1
    } bk_state_e;

    localparam int unsigned LANE_N = 4;
    localparam int unsigned OFS_W  = 2;
    localparam int unsigned CTRL_W = 6;

    typedef struct packed {
        logic [1:0] size;
        logic       szmask;
        logic [1:0] dir;
        logic       en;
    } bk_ctrl_t;

endpackage

// File: rtl/bkpt_lane_decode.sv
module bkpt_lane_decode
    import bkpt_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [OFS_W-1:0]  ofs,
    output logic [LANE_N-1:0] lanes
);
    logic [LANE_N-1:0]   base;
    logic [2*LANE_N-1:0] wide;

    always_comb begin
        unique case (bk_size_e'(size))
            SZ_LONG: base = 4'b1111;
            SZ_BYTE: base = 4'b0001;
            SZ_WORD: base = 4'b0011;
            SZ_TRI:  base = 4'b0111;
            default: base = 4'b0000;
        endcase
        wide  = {{LANE_N{1'b0}}, base} << ofs;
        lanes = wide[LANE_N-1:0];
    end
endmodule

// File: rtl/bkpt_cfg_regs.sv
module bkpt_cfg_regs
    import bkpt_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cmp_addr,
    output bk_ctrl_t          ctrl
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_addr <= '0;
            ctrl     <= '0;
        end else if (cfg_wr) begin
            if (cfg_sel) ctrl     <= bk_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
            else         cmp_addr <= cfg_wdata;
        end
    end
endmodule

// File: rtl/bkpt_match.sv
module bkpt_match
    import bkpt_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_rd,
    input  logic [1:0]        acc_size,
    input  logic              acc_cont,
    input  logic              acc_ext,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  bk_ctrl_t          ctrl,
    output logic              hit
);
    logic [LANE_N-1:0] acc_lanes;
    logic [LANE_N-1:0] cmp_lanes;
    logic dir_ok, upper_eq, full_eq, size_off, addr_ok;

    bkpt_lane_decode u_acc_lanes (
        .size (acc_size),
        .ofs  (acc_addr[OFS_W-1:0]),
        .lanes(acc_lanes)
    );

    bkpt_lane_decode u_cmp_lanes (
        .size (ctrl.size),
        .ofs  (cmp_addr[OFS_W-1:0]),
        .lanes(cmp_lanes)
    );

    always_comb begin
        unique case (bk_dir_e'(ctrl.dir))
            DIR_RD:   dir_ok = acc_rd;
            DIR_WR:   dir_ok = !acc_rd;
            DIR_ANY:  dir_ok = 1'b1;
            DIR_RSVD: dir_ok = 1'b0;
            default:  dir_ok = 1'b0;
        endcase
        upper_eq = (acc_addr[ADDR_W-1:OFS_W] == cmp_addr[ADDR_W-1:OFS_W]);
        full_eq  = upper_eq && (acc_addr[OFS_W-1:0] == cmp_addr[OFS_W-1:0]);
        size_off = ctrl.szmask || acc_ext;
        addr_ok  = size_off ? full_eq : (upper_eq && |(acc_lanes & cmp_lanes));
        hit      = ctrl.en && acc_valid && !acc_cont && dir_ok && addr_ok;
    end
endmodule

// File: rtl/bkpt_cmp.sv
module bkpt_cmp
    import bkpt_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_rd,
    input  logic [1:0]        acc_size,
    input  logic              acc_cont,
    input  logic              acc_ext,
    output logic              brk
);
    logic [ADDR_W-1:0] cmp_addr;
    bk_ctrl_t          ctrl;
    logic              hit;
    bk_state_e         state, state_nx;

    bkpt_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .cmp_addr (cmp_addr),
        .ctrl     (ctrl)
    );

    bkpt_match #(.ADDR_W(ADDR_W)) u_match (
        .acc_valid(acc_valid),
        .acc_addr (acc_addr),
        .acc_rd   (acc_rd),
        .acc_size (acc_size),
        .acc_cont (acc_cont),
        .acc_ext  (acc_ext),
        .cmp_addr (cmp_addr),
        .ctrl     (ctrl),
        .hit      (hit)
    );

    // Next state: HIT (ARMED->FIRE), REHIT (FIRE->FIRE), MISS (FIRE->ARMED)
    always_comb begin
        unique case (state)
            ST_ARMED: state_nx = hit ? ST_FIRE : ST_ARMED;
            ST_FIRE:  state_nx = hit ? ST_FIRE : ST_ARMED;
            default:  state_nx = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ARMED;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_ARMED: brk = 1'b0;
            ST_FIRE:  brk = 1'b1;
            default:  brk = 1'b0;
        endcase
    end
endmodule

// File: rtl/bkpt_cmp_chk.sv
module bkpt_cmp_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_rd,
    input logic              acc_cont,
    input logic              acc_ext,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [ADDR_W-1:0] cmp_addr,
    input logic              en_f,
    input logic [1:0]        dir_f,
    input logic              szm_f,
    input logic              brk
);
    a_r11_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> $past(acc_valid));
    a_r10_no_cont_beat: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> !$past(acc_cont));
    a_r2_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> $past(en_f));
    a_r4_reserved_dir: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> ($past(dir_f) != 2'b11));
    a_r3_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        (brk && $past(dir_f) == 2'b00) |-> $past(acc_rd));
    a_r3_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        (brk && $past(dir_f) == 2'b01) |-> !$past(acc_rd));
    a_r5_upper_eq: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> ($past(acc_addr[ADDR_W-1:2]) == $past(cmp_addr[ADDR_W-1:2])));
    a_r9_ext_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (brk && ($past(acc_ext) || $past(szm_f))) |-> ($past(acc_addr) == $past(cmp_addr)));
endmodule

bind bkpt_cmp bkpt_cmp_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_valid(acc_valid),
    .acc_rd   (acc_rd),
    .acc_cont (acc_cont),
    .acc_ext  (acc_ext),
    .acc_addr (acc_addr),
    .cmp_addr (cmp_addr),
    .en_f     (ctrl.en),
    .dir_f    (ctrl.dir),
    .szm_f    (ctrl.szmask),
    .brk      (brk)
);

// File: tb/bkpt_cmp_tb.sv
module bkpt_cmp_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0, cfg_sel = 1'b0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          acc_valid = 1'b0, acc_rd = 1'b0, acc_cont = 1'b0, acc_ext = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [1:0]    acc_size = 2'b00;
    logic          brk;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // model state
    logic [AW-1:0] m_addr = '0;
    logic [5:0]    m_ctrl = '0;
    bit            exp_q = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bkpt_cmp #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_rd(acc_rd), .acc_size(acc_size), .acc_cont(acc_cont),
        .acc_ext(acc_ext), .brk(brk)
    );

    function automatic int nbytes(input logic [1:0] s);
        case (s)
            2'b00: return 4;
            2'b01: return 1;
            2'b10: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic bit covers(input int b, input int ofs, input int n);
        return (b >= ofs) && (b < ofs + n);
    endfunction

    function automatic bit model_hit();
        bit dir_ok, ovl;
        if (!m_ctrl[0] || !acc_valid || acc_cont) return 0;
        case (m_ctrl[2:1])
            2'b00: dir_ok = acc_rd;
            2'b01: dir_ok = !acc_rd;
            2'b10: dir_ok = 1;
            default: dir_ok = 0;
        endcase
        if (!dir_ok) return 0;
        if ((acc_addr >> 2) != (m_addr >> 2)) return 0;
        if (m_ctrl[3] || acc_ext) return acc_addr == m_addr;
        ovl = 0;
        for (int b = 0; b < 4; b++)
            if (covers(b, int'(acc_addr[1:0]), nbytes(acc_size)) &&
                covers(b, int'(m_addr[1:0]), nbytes(m_ctrl[5:4])))
                ovl = 1;
        return ovl;
    endfunction

    task automatic check(input string tag);
        total++;
        if (brk !== exp_q) begin
            bad++;
            $display("FAIL %s: brk=%0b expected=%0b", tag, brk, exp_q);
        end
    endtask

    // one clock: inputs already set at negedge; model updates at posedge; check at next negedge
    task automatic tick(input string tag);
        bit nx;
        nx = model_hit();
        @(posedge clk);
        if (cfg_wr) begin
            if (cfg_sel) m_ctrl = cfg_wdata[5:0];
            else         m_addr = cfg_wdata;
        end
        exp_q = nx;
        @(negedge clk);
        check(tag);
        cfg_wr = 0;
        acc_valid = 0;
        acc_cont = 0;
        acc_ext = 0;
    endtask

    task automatic wr(input bit sel, input logic [AW-1:0] d, input string tag);
        cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
        tick(tag);
    endtask

    task automatic acc(input logic [AW-1:0] a, input bit rd, input logic [1:0] sz,
                       input bit cont, input bit ext, input string tag);
        acc_valid = 1; acc_addr = a; acc_rd = rd; acc_size = sz;
        acc_cont = cont; acc_ext = ext;
        tick(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 during reset");
        rst_n = 1;
        @(negedge clk);
        check("R1 after reset");
        // defaults: enable off
        acc(32'h0, 1, 2'b00, 0, 0, "R2 default disabled");
        acc(32'h0, 1, 2'b01, 0, 0, "R1 zero regs no hit");
        // program word @ ...02, read only, size compared
        wr(0, 32'h1000_0002, "R12 addr write");
        acc(32'h1000_0002, 1, 2'b10, 0, 0, "R12 en still off");
        wr(1, 32'h21, "R12 ctrl write");
        acc(32'h1000_0002, 1, 2'b10, 0, 0, "R7 word@2");
        acc(32'h1000_0000, 1, 2'b00, 0, 0, "R7 long@0");
        acc(32'h1000_0000, 1, 2'b10, 0, 0, "R7 word@0 miss");
        acc(32'h1000_0003, 1, 2'b01, 0, 0, "R6 byte@3");
        acc(32'h1000_0001, 1, 2'b01, 0, 0, "R6 byte@1 miss");
        acc(32'h1000_0001, 1, 2'b11, 0, 0, "R6 tri@1");
        acc(32'h1000_0003, 1, 2'b00, 0, 0, "R6 long@3 clipped");
        acc(32'h1000_0002, 0, 2'b10, 0, 0, "R3 write vs read-only");
        acc(32'h1000_0006, 1, 2'b10, 0, 0, "R5 next long word");
        acc(32'h2000_0002, 1, 2'b10, 0, 0, "R5 high bit diff");
        acc(32'h1000_0002, 1, 2'b10, 0, 0, "R11 back-to-back 1");
        acc(32'h1000_0002, 1, 2'b10, 0, 0, "R11 back-to-back 2");
        tick("R11 idle after hit");
        acc(32'h1000_0002, 1, 2'b10, 1, 0, "R10 cont beat");
        acc(32'h1000_0000, 1, 2'b00, 0, 1, "R9 ext long@0 miss");
        acc(32'h1000_0002, 1, 2'b01, 0, 1, "R9 ext byte@2 hit");
        // size masked
        wr(1, 32'h29, "R8 ctrl");
        acc(32'h1000_0000, 1, 2'b00, 0, 0, "R8 long@0 miss");
        acc(32'h1000_0002, 1, 2'b01, 0, 0, "R8 byte@2 hit");
        // direction modes
        wr(1, 32'h23, "R3 ctrl wr-only");
        acc(32'h1000_0002, 0, 2'b10, 0, 0, "R3 write hit");
        acc(32'h1000_0002, 1, 2'b10, 0, 0, "R3 read miss");
        wr(1, 32'h25, "R3 ctrl both");
        acc(32'h1000_0002, 0, 2'b10, 0, 0, "R3 both write");
        acc(32'h1000_0002, 1, 2'b10, 0, 0, "R3 both read");
        wr(1, 32'h27, "R4 ctrl reserved");
        acc(32'h1000_0002, 0, 2'b10, 0, 0, "R4 write");
        acc(32'h1000_0002, 1, 2'b10, 0, 0, "R4 read");
        wr(1, 32'h24, "R2 ctrl disabled");
        acc(32'h1000_0002, 1, 2'b10, 0, 0, "R2 disabled");
        // write and access in the same cycle: old value applies
        cfg_wr = 1; cfg_sel = 1; cfg_wdata = 32'h25;
        acc(32'h1000_0002, 1, 2'b10, 0, 0, "R12 same-cycle old value");
        acc(32'h1000_0002, 1, 2'b10, 0, 0, "R12 new value next");
        // mixed pseudo-random traffic
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 9) == 0) begin
                cfg_wr = 1; cfg_sel = $urandom_range(0, 1);
                cfg_wdata = cfg_sel ? 32'($urandom_range(0, 63))
                                    : {30'h0400_0000 + 30'($urandom_range(0, 1)), 2'($urandom_range(0, 3))};
            end
            acc_valid = $urandom_range(0, 3) != 0;
            acc_addr  = {30'h0400_0000 + 30'($urandom_range(0, 1)), 2'($urandom_range(0, 3))};
            acc_rd    = $urandom_range(0, 1);
            acc_size  = 2'($urandom_range(0, 3));
            acc_cont  = $urandom_range(0, 4) == 0;
            acc_ext   = $urandom_range(0, 4) == 0;
            tick("R6 R11 mixed traffic");
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule